// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the 64-bit memory address of a load or store and, for the forms that update their base register, supplies the value and enable for writing that address back into the base register. It takes an operation that has already been decoded. The inputs are the address form, an update flag, the base register index, the two register values read for the operation, and the 16-bit immediate field of the instruction. It returns the address one cycle after it accepts the request.

Four address forms are supported:
- A plain signed 16-bit displacement.
- A displacement scaled by 4.
- A displacement scaled by 16.
- An indexed form that adds the second register value.

In non-update forms, a base index of zero selects a literal zero base instead of the register contents. Update forms always use the register contents. An update form that names register zero is flagged as illegal, and its writeback is suppressed.

Requests enter through a valid/ready handshake into a single output register. A new request is taken whenever that register is empty or is being drained in the same cycle. Addition wraps modulo 2^64.

Top module: `ea_gen`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: In a non-update request (`in_update`=0) with `in_ra_idx`=0, the base is zero regardless of `in_ra_val`. With any other index the base is `in_ra_val`.
- R3: Form code 0 (D) gives address = base + sign-extend64(`in_imm`).
- R4: Form code 1 (DS) gives address = base + sign-extend64({`in_imm`[15:2], 2'b00}). Bits 1:0 of `in_imm` are ignored.
- R5: Form code 2 (DQ) gives address = base + sign-extend64({`in_imm`[15:4], 4'b0000}). Bits 3:0 of `in_imm` are ignored.
- R6: Form code 3 (indexed) gives address = base + `in_rb_val`.
- R7: An update request with a nonzero `in_ra_idx` uses `in_ra_val` as the base and sets `out_wb_en`=1. `out_wb_val` always equals `out_ea`.
- R8: An update request with `in_ra_idx`=0 sets `out_illegal`=1 and `out_wb_en`=0, with the address still computed from `in_ra_val`. Every other request gives `out_illegal`=0.
- R9: The addition wraps modulo 2^64 and carries out of bit 63 are dropped.
- R10: While `out_valid`=1 and `out_ready`=0, every output stays unchanged.
- R11: `in_ready` = !`out_valid` || `out_ready`. A request accepted at a clock edge is presented with `out_valid`=1 from that edge on. A consumed result with no new request accepted clears `out_valid`.
- R12: Non-indexed forms ignore `in_rb_val`. The indexed form ignores `in_imm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_form | input | 2 | Address form: 0 D, 1 DS, 2 DQ, 3 indexed |
| in_update | input | 1 | Update form (write address back to base) |
| in_ra_idx | input | 5 | Base register index |
| in_ra_val | input | 64 | Base register contents |
| in_rb_val | input | 64 | Index register contents |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ea | output | 64 | Effective address |
| out_wb_en | output | 1 | Base register writeback enable |
| out_wb_val | output | 64 | Base register writeback value |
| out_illegal | output | 1 | Update form named register zero |

## Verification
The block has no hidden state beyond the single result register. A wrong offset, scale or base choice therefore shows on `out_ea` in the cycle right after acceptance. A faulty handshake shows in one of two ways. A dropped or duplicated result makes `out_valid` disagree with a one-entry model at the next edge. An overwrite under backpressure changes `out_ea` while `out_ready` is low. Each result is compared against an address computed independently, under random backpressure, random forms and frequent zero indices, along with directed wrap and sign-boundary immediates.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int XLEN     = 64;
    localparam int IMM_W    = 16;
    localparam int IDX_W    = 5;
    localparam int DS_SHIFT = 2;
    localparam int DQ_SHIFT = 4;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        FORM_D  = 2'd0,
        FORM_DS = 2'd1,
        FORM_DQ = 2'd2,
        FORM_X  = 2'd3
    } addr_form_e;

    typedef struct packed {
        word_t ea;
        logic  wb_en;
        logic  illegal;
    } agu_rsp_t;

    // sign-extend the immediate and clear its low 'shift' bits
    function automatic word_t scaled_sext(input logic [IMM_W-1:0] imm,
                                          input int unsigned shift);
        word_t v;
        v = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        return v & ~((word_t'(1) << shift) - word_t'(1));
    endfunction
endpackage

// File: rtl/agu_offset.sv
module agu_offset
    import agu_pkg::*;
#(
    parameter int DS_SH = DS_SHIFT,
    parameter int DQ_SH = DQ_SHIFT
) (
    input  addr_form_e       form,
    input  logic [IMM_W-1:0] imm,
    input  word_t            rb_val,
    output word_t            offset
);
    always_comb begin
        unique case (form)
            FORM_D:  offset = scaled_sext(imm, 0);
            FORM_DS: offset = scaled_sext(imm, DS_SH);
            FORM_DQ: offset = scaled_sext(imm, DQ_SH);
            default: offset = rb_val;
        endcase
    end
endmodule

// File: rtl/agu_base.sv
module agu_base
    import agu_pkg::*;
(
    input  logic             update,
    input  logic [IDX_W-1:0] ra_idx,
    input  word_t            ra_val,
    output word_t            base,
    output logic             wb_en,
    output logic             illegal
);
    logic idx_zero;
    assign idx_zero = (ra_idx == '0);

    always_comb begin
        base    = (update || !idx_zero) ? ra_val : '0;
        wb_en   = update && !idx_zero;
        illegal = update && idx_zero;
    end
endmodule

// File: rtl/agu_stage.sv
module agu_stage
    import agu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    output logic     in_ready,
    input  agu_rsp_t in_rsp,
    output logic     out_valid,
    input  logic     out_ready,
    output agu_rsp_t out_rsp
);
    logic accept;
    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rsp   <= '0;
        end else begin
            if (accept) begin
                out_valid <= 1'b1;
                out_rsp   <= in_rsp;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_rsp));

    // R11
    accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    // R11
    drain_clears_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import agu_pkg::*;
#(
    parameter int DS_SH = DS_SHIFT,
    parameter int DQ_SH = DQ_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_form,
    input  logic             in_update,
    input  logic [IDX_W-1:0] in_ra_idx,
    input  logic [XLEN-1:0]  in_ra_val,
    input  logic [XLEN-1:0]  in_rb_val,
    input  logic [IMM_W-1:0] in_imm,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [XLEN-1:0]  out_ea,
    output logic             out_wb_en,
    output logic [XLEN-1:0]  out_wb_val,
    output logic             out_illegal
);
    word_t    base, offset;
    logic     wb_en_c, illegal_c;
    agu_rsp_t rsp_d, rsp_q;

    agu_base u_base (
        .update (in_update),
        .ra_idx (in_ra_idx),
        .ra_val (in_ra_val),
        .base   (base),
        .wb_en  (wb_en_c),
        .illegal(illegal_c)
    );

    agu_offset #(.DS_SH(DS_SH), .DQ_SH(DQ_SH)) u_offset (
        .form  (addr_form_e'(in_form)),
        .imm   (in_imm),
        .rb_val(in_rb_val),
        .offset(offset)
    );

    always_comb begin
        rsp_d.ea      = base + offset;   // modulo 2^XLEN
        rsp_d.wb_en   = wb_en_c;
        rsp_d.illegal = illegal_c;
    end

    agu_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_rsp   (rsp_d),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_rsp  (rsp_q)
    );

    assign out_ea      = rsp_q.ea;
    assign out_wb_en   = rsp_q.wb_en;
    assign out_wb_val  = rsp_q.ea;
    assign out_illegal = rsp_q.illegal;

    // R2
    zero_base_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_update && in_ra_idx == '0 && in_form == 2'd3
        |=> out_ea == $past(in_rb_val));

    // R8
    illegal_upd_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_update && in_ra_idx == '0
        |=> out_illegal && !out_wb_en);

    // R7
    upd_wb_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_update && in_ra_idx != '0
        |=> out_wb_en && !out_illegal);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  in_form;
    logic        in_update;
    logic [4:0]  in_ra_idx;
    logic [63:0] in_ra_val, in_rb_val;
    logic [15:0] in_imm;
    logic        out_valid, out_ready;
    logic [63:0] out_ea, out_wb_val;
    logic        out_wb_en, out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    ea_gen uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_form(in_form), .in_update(in_update), .in_ra_idx(in_ra_idx),
        .in_ra_val(in_ra_val), .in_rb_val(in_rb_val), .in_imm(in_imm),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_ea(out_ea), .out_wb_en(out_wb_en), .out_wb_val(out_wb_val),
        .out_illegal(out_illegal)
    );

    // one-entry model of the output register
    bit          m_valid = 0;
    logic [63:0] m_ea;
    bit          m_wb, m_ill;
    string       m_tag;
    bit          p_hold = 0;
    logic [63:0] p_ea;

    function automatic logic [63:0] ref_ea(input logic [1:0] f, input logic u,
        input logic [4:0] idx, input logic [63:0] ra, input logic [63:0] rb,
        input logic [15:0] imm);
        logic [63:0] b, o;
        b = (u || idx != 0) ? ra : 64'd0;
        case (f)
            2'd0: o = {{48{imm[15]}}, imm};
            2'd1: o = {{48{imm[15]}}, imm[15:2], 2'b00};
            2'd2: o = {{48{imm[15]}}, imm[15:4], 4'b0000};
            default: o = rb;
        endcase
        return b + o;
    endfunction

    function automatic string ref_tag(input logic [1:0] f, input logic u,
        input logic [4:0] idx);
        if (!u && idx == 0) return "R2";
        case (f)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [1:0] f, input logic u,
        input logic [4:0] idx, input logic [63:0] ra, input logic [63:0] rb,
        input logic [15:0] imm, input logic rdy);
        bit acc, con;
        check(out_valid == m_valid, "R11 out_valid", 64'(out_valid), 64'(m_valid));
        if (m_valid) begin
            check(out_ea == m_ea, m_tag, out_ea, m_ea);
            check(out_wb_val == m_ea, "R7 wb_val", out_wb_val, m_ea);
            check(out_wb_en == m_wb, "R7 wb_en", 64'(out_wb_en), 64'(m_wb));
            check(out_illegal == m_ill, "R8 illegal", 64'(out_illegal), 64'(m_ill));
            if (p_hold) check(out_ea == p_ea, "R10 hold", out_ea, p_ea);
        end
        in_valid = v; in_form = f; in_update = u; in_ra_idx = idx;
        in_ra_val = ra; in_rb_val = rb; in_imm = imm; out_ready = rdy;
        #1;
        check(in_ready == (!m_valid || rdy), "R11 in_ready",
              64'(in_ready), 64'(!m_valid || rdy));
        acc    = v && (!m_valid || rdy);
        con    = m_valid && rdy;
        p_hold = m_valid && !rdy;
        p_ea   = out_ea;
        if (con) m_valid = 0;
        if (acc) begin
            m_valid = 1;
            m_ea    = ref_ea(f, u, idx, ra, rb, imm);
            m_wb    = u && idx != 0;
            m_ill   = u && idx == 0;
            m_tag   = ref_tag(f, u, idx);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; in_valid = 0; out_ready = 0; in_form = 0; in_update = 0;
        in_ra_idx = 0; in_ra_val = 0; in_rb_val = 0; in_imm = 0;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(in_ready == 1, "R1 in_ready", 64'(in_ready), 64'd1);

        // directed corner cases
        // R9 wrap: all-ones base plus 1
        cycle(1, 2'd0, 0, 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5, 16'h0001, 1);
        // R2 zero index ignores register contents
        cycle(1, 2'd0, 0, 5'd0, 64'h1234_5678_9ABC_DEF0, 64'h0, 16'h8000, 1);
        // R4 low bits dropped, negative DS
        cycle(1, 2'd1, 0, 5'd7, 64'h1000, 64'hDEAD, 16'hFFFF, 1);
        // R5 low bits dropped, positive DQ at sign boundary
        cycle(1, 2'd2, 0, 5'd7, 64'h1000, 64'hDEAD, 16'h7FFF, 1);
        // R6 / R12 indexed ignores imm, R9 wrap through rb
        cycle(1, 2'd3, 0, 5'd9, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 16'h7777, 1);
        // R7 update with nonzero index
        cycle(1, 2'd1, 1, 5'd4, 64'h40, 64'h0, 16'hFFF8, 1);
        // R8 update with index zero: base still ra
        cycle(1, 2'd0, 1, 5'd0, 64'h100, 64'h0, 16'h0010, 1);
        // R10 backpressure: hold several cycles while new requests wait
        cycle(1, 2'd3, 0, 5'd1, 64'h11, 64'h22, 16'h0, 0);
        cycle(1, 2'd0, 0, 5'd1, 64'h99, 64'h0, 16'h5, 0);
        cycle(1, 2'd0, 0, 5'd1, 64'h99, 64'h0, 16'h5, 0);
        cycle(0, 2'd0, 0, 5'd1, 64'h0, 64'h0, 16'h0, 1);
        cycle(0, 2'd0, 0, 5'd1, 64'h0, 64'h0, 16'h0, 1);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] idx;
            idx = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            cycle(1'($urandom % 4 != 0), 2'($urandom), 1'($urandom),
                  idx, {$urandom, $urandom}, {$urandom, $urandom},
                  16'($urandom), 1'($urandom % 3 != 0));
        end
        cycle(0, 2'd0, 0, 5'd0, 64'h0, 64'h0, 16'h0, 1);
        cycle(0, 2'd0, 0, 5'd0, 64'h0, 64'h0, 16'h0, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule